// File: doc/BRIEF.md
# Multi-Mode 24-bit Timer Core

The block is a 24-bit up-counter with three working modes (interval timer, pulse generator and watchdog) and a fourth setting in which the counter is frozen. Each step of the counter is gated by a count enable. The enable comes either from a free-running internal prescaler or from an asynchronous external tick. The external tick is resynchronised, and one step is taken per rising edge.

The count is compared against two compare values. A match produces a one-cycle set strobe for the matching status flag, and it can raise a level interrupt. In pulse-generator mode a match also toggles a flip-flop output. The control fields arrive already decoded from a register bank that sits outside the block.

A synchronous reset returns the counter to its start state. It also clears the pending interrupt and presets the flip-flop from its initial-value bit.

Top module: `mtimer_core`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `set_o`, `irq_o` and `ff_o` are all 0. A clock edge with `sync_rst_i` high clears `count_o`, the prescaler and `irq_o`, and loads `ff_o` from `ffi_i`.
- R2: With `mode_i` = 3 (disabled), `count_o` never changes, whatever the enable inputs are.
- R3: With `clk_src_i` = 0 and `div_en_i` = 0, the counter may step on every clock. With `div_en_i` = 1, it steps once every 2^(1+`div_sel_i`) clocks, counted from the last synchronous reset. With `clk_src_i` = 1, the internal prescaler has no effect on the count.
- R4: With `clk_src_i` = 1, each rising edge of `ext_tick_i` steps the counter exactly once, after a two-flop synchroniser. A level held high produces a single step.
- R5: With `mode_i` = 0 (interval), the counter advances only while `tmr_en_i` = 1 and `count_o` differs from `cmp_a_i`. With `zero_clr_en_i` = 0 it stops and holds at `cmp_a_i`, and no further event follows.
- R6: In interval mode, a step onto `cmp_a_i` pulses `set_o[0]` and raises the interrupt if `int_ival_en_i` = 1. If `zero_clr_en_i` = 1, `count_o` becomes 0 instead of `cmp_a_i`.
- R7: With `mode_i` = 1 (pulse), a step onto `cmp_a_i` toggles `ff_o`, pulses `set_o[1]` and raises the interrupt if `int_a_en_i` = 1.
- R8: In pulse mode, a step onto `cmp_b_i` (when that value is not also `cmp_a_i`) toggles `ff_o`, pulses `set_o[2]`, raises the interrupt if `int_b_en_i` = 1, and leaves `count_o` at 0.
- R9: With `mode_i` = 2 (watchdog), the counter advances unless `tmr_en_i` = 0 and `wd_dis_i` = 1. A step onto `cmp_a_i` pulses `set_o[3]`, raises the interrupt if `int_wd_en_i` = 1, and leaves `count_o` at 0.
- R10: Once raised, `irq_o` stays high until a clock edge with `status_clr_i` = 1. A raise in that same edge keeps it high.
- R11: The set strobes in `set_o` last one clock each and appear on the same edge on which `count_o` takes its post-match value. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous reset of counter, prescaler, interrupt; presets flip-flop |
| ext_tick_i | input | 1 | Asynchronous external count tick |
| mode_i | input | 2 | 0 interval, 1 pulse, 2 watchdog, 3 disabled |
| tmr_en_i | input | 1 | Timer enable |
| clk_src_i | input | 1 | 0 internal clock, 1 external tick |
| div_en_i | input | 1 | Enable internal prescaler |
| div_sel_i | input | 3 | Prescaler code D, divide by 2^(1+D) |
| zero_clr_en_i | input | 1 | Interval mode: reload 0 on match |
| wd_dis_i | input | 1 | Watchdog disable (effective while timer enable is 0) |
| int_ival_en_i | input | 1 | Interval match interrupt enable |
| int_a_en_i | input | 1 | Pulse compare A interrupt enable |
| int_b_en_i | input | 1 | Pulse compare B interrupt enable |
| int_wd_en_i | input | 1 | Watchdog interrupt enable |
| ffi_i | input | 1 | Flip-flop value loaded by synchronous reset |
| cmp_a_i | input | 24 | Compare value A |
| cmp_b_i | input | 24 | Compare value B |
| status_clr_i | input | 1 | Clears the interrupt level |
| count_o | output | 24 | Counter value |
| set_o | output | 4 | Set strobes: [0] interval, [1] pulse A, [2] pulse B, [3] watchdog |
| irq_o | output | 1 | Interrupt request level |
| ff_o | output | 1 | Toggle flip-flop output |

## Verification
The assertions treat the mode, enables and compare values as register fields that change only between clock edges, and `ext_tick_i` as fully asynchronous. They do not assume that the compare values stay fixed while the counter holds. The stimulus drives every input at falling edges. It reprograms the configuration only together with a synchronous reset. External ticks are given as pulses with at least one low clock between them, so the edge detector sees each one.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  typedef enum logic [1:0] {
    MODE_IVAL  = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_WDOG  = 2'd2,
    MODE_OFF   = 2'd3
  } mode_e;

  localparam int unsigned NUM_EVT  = 4;
  localparam int unsigned EVT_IVAL = 0;
  localparam int unsigned EVT_PA   = 1;
  localparam int unsigned EVT_PB   = 2;
  localparam int unsigned EVT_WD   = 3;
endpackage

// File: rtl/mtimer_tick_gen.sv
module mtimer_tick_gen #(
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_rst_i,
  input  logic             ext_tick_i,
  input  logic             clk_src_i,
  input  logic             div_en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             step_o
);
  localparam int unsigned PRESC_W = 1 << DIV_W;

  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W-1:0] mask;
  logic [SYNC_N:0]    ext_q;
  logic               int_tick;
  logic               ext_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         presc_q <= '0;
    else if (sync_rst_i) presc_q <= '0;
    else                 presc_q <= presc_q + PRESC_W'(1);
  end

  // mask of 1+D low ones; wraps to all ones at the top code
  assign mask     = (PRESC_W'(2) << div_sel_i) - PRESC_W'(1);
  assign int_tick = div_en_i ? &(presc_q | ~mask) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ext_q <= '0;
    else if (sync_rst_i) ext_q <= '0;
    else                 ext_q <= {ext_q[SYNC_N-1:0], ext_tick_i};
  end

  assign ext_edge = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];
  assign step_o   = clk_src_i ? ext_edge : int_tick;

  AST_EXT_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_edge |=> !ext_edge); // R4
endmodule

// File: rtl/mtimer_count.sv
module mtimer_count
  import mtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_rst_i,
  input  logic               step_i,
  input  logic [1:0]         mode_i,
  input  logic               tmr_en_i,
  input  logic               wd_dis_i,
  input  logic               zero_clr_en_i,
  input  logic [CNT_W-1:0]   cmp_a_i,
  input  logic [CNT_W-1:0]   cmp_b_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_EVT-1:0] evt_o
);
  mode_e            mode;
  logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
  logic             run;

  assign mode = mode_e'(mode_i);
  assign nxt  = cnt_q + CNT_W'(1);

  always_comb begin
    case (mode)
      MODE_IVAL:  run = tmr_en_i && (cnt_q != cmp_a_i);
      MODE_PULSE: run = tmr_en_i;
      MODE_WDOG:  run = tmr_en_i || !wd_dis_i;
      default:    run = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    evt_o = '0;
    if (step_i && run) begin
      cnt_d = nxt;
      case (mode)
        MODE_IVAL: begin
          if (nxt == cmp_a_i) begin
            evt_o[EVT_IVAL] = 1'b1;
            if (zero_clr_en_i) cnt_d = '0;
          end
        end
        MODE_PULSE: begin
          if (nxt == cmp_a_i) begin
            evt_o[EVT_PA] = 1'b1;
          end else if (nxt == cmp_b_i) begin
            evt_o[EVT_PB] = 1'b1;
            cnt_d = '0;
          end
        end
        MODE_WDOG: begin
          if (nxt == cmp_a_i) begin
            evt_o[EVT_WD] = 1'b1;
            cnt_d = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (sync_rst_i) cnt_q <= '0;
    else                 cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  AST_OFF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !sync_rst_i) |=> $stable(cnt_q)); // R2
  AST_NO_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !sync_rst_i) |=> $stable(cnt_q)); // R3
  AST_IVAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !sync_rst_i && cnt_q == cmp_a_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/mtimer_event.sv
module mtimer_event
  import mtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_rst_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] int_en_i,
  input  logic               status_clr_i,
  input  logic               ffi_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic [NUM_EVT-1:0] set_o,
  output logic               irq_o,
  output logic               ff_o
);
  logic raise;
  logic toggle;

  assign raise  = |(evt_i & int_en_i);
  assign toggle = evt_i[EVT_PA] | evt_i[EVT_PB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o <= '0;
      irq_o <= 1'b0;
      ff_o  <= 1'b0;
    end else if (sync_rst_i) begin
      set_o <= '0;
      irq_o <= 1'b0;
      ff_o  <= ffi_i;
    end else begin
      set_o <= evt_i;
      if (raise)             irq_o <= 1'b1;
      else if (status_clr_i) irq_o <= 1'b0;
      if (toggle) ff_o <= ~ff_o;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_o)); // R11
  AST_STROBE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_o) |=> (set_o != $past(set_o))); // R11
  AST_WD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[EVT_WD] |-> (count_i == '0)); // R9
  AST_PB_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[EVT_PB] |-> (count_i == '0)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !status_clr_i && !sync_rst_i) |=> irq_o); // R10
  AST_FF_ONLY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_rst_i && !toggle) |=> $stable(ff_o)); // R7
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
  import mtimer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_rst_i,
  input  logic               ext_tick_i,
  input  logic [1:0]         mode_i,
  input  logic               tmr_en_i,
  input  logic               clk_src_i,
  input  logic               div_en_i,
  input  logic [DIV_W-1:0]   div_sel_i,
  input  logic               zero_clr_en_i,
  input  logic               wd_dis_i,
  input  logic               int_ival_en_i,
  input  logic               int_a_en_i,
  input  logic               int_b_en_i,
  input  logic               int_wd_en_i,
  input  logic               ffi_i,
  input  logic [CNT_W-1:0]   cmp_a_i,
  input  logic [CNT_W-1:0]   cmp_b_i,
  input  logic               status_clr_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_EVT-1:0] set_o,
  output logic               irq_o,
  output logic               ff_o
);
  logic               step;
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] int_en;

  always_comb begin
    int_en           = '0;
    int_en[EVT_IVAL] = int_ival_en_i;
    int_en[EVT_PA]   = int_a_en_i;
    int_en[EVT_PB]   = int_b_en_i;
    int_en[EVT_WD]   = int_wd_en_i;
  end

  mtimer_tick_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) tick_gen_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_rst_i (sync_rst_i),
    .ext_tick_i (ext_tick_i),
    .clk_src_i  (clk_src_i),
    .div_en_i   (div_en_i),
    .div_sel_i  (div_sel_i),
    .step_o     (step)
  );

  mtimer_count #(.CNT_W(CNT_W)) count_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sync_rst_i    (sync_rst_i),
    .step_i        (step),
    .mode_i        (mode_i),
    .tmr_en_i      (tmr_en_i),
    .wd_dis_i      (wd_dis_i),
    .zero_clr_en_i (zero_clr_en_i),
    .cmp_a_i       (cmp_a_i),
    .cmp_b_i       (cmp_b_i),
    .count_o       (count_o),
    .evt_o         (evt)
  );

  mtimer_event #(.CNT_W(CNT_W)) event_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_rst_i   (sync_rst_i),
    .evt_i        (evt),
    .int_en_i     (int_en),
    .status_clr_i (status_clr_i),
    .ffi_i        (ffi_i),
    .count_i      (count_o),
    .set_o        (set_o),
    .irq_o        (irq_o),
    .ff_o         (ff_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (count_o == '0 && set_o == '0 && !irq_o)); // R1
endmodule

// File: tb/mtimer_core_tb_top.sv
module mtimer_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_rst_i = 1'b0;
  logic        ext_tick_i = 1'b0;
  logic [1:0]  mode_i = 2'd3;
  logic        tmr_en_i = 1'b0, clk_src_i = 1'b0, div_en_i = 1'b0;
  logic [2:0]  div_sel_i = 3'd0;
  logic        zero_clr_en_i = 1'b0, wd_dis_i = 1'b0;
  logic        int_ival_en_i = 1'b0, int_a_en_i = 1'b0, int_b_en_i = 1'b0, int_wd_en_i = 1'b0;
  logic        ffi_i = 1'b0;
  logic [23:0] cmp_a_i = 24'hFFFFFF, cmp_b_i = 24'hFFFFFF;
  logic        status_clr_i = 1'b0;
  logic [23:0] count_o;
  logic [3:0]  set_o;
  logic        irq_o, ff_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  mtimer_core dut_i (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        en, wd_dis, zc, ie_iv, ie_a, ie_b, ie_wd, ffi;
    logic [23:0] ca, cb;
    logic [7:0]  n;
    logic [23:0] exp_cnt;
    logic        exp_ff, exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1,0,0,1,0,0,0,0, 24'd5, 24'hFFFFFF, 8'd3,  24'd3, 0,0, 8'd5},  // R5 counting up
    '{2'd0,1,0,0,1,0,0,0,0, 24'd5, 24'hFFFFFF, 8'd10, 24'd5, 0,1, 8'd5},  // R5 hold at A
    '{2'd0,1,0,1,1,0,0,0,0, 24'd5, 24'hFFFFFF, 8'd8,  24'd3, 0,1, 8'd6},  // R6 reload 0
    '{2'd0,0,0,0,1,0,0,0,0, 24'd5, 24'hFFFFFF, 8'd10, 24'd0, 0,0, 8'd5},  // R5 disabled
    '{2'd1,1,0,0,0,1,0,0,0, 24'd3, 24'd6,      8'd7,  24'd1, 0,1, 8'd8},  // R8 A then B
    '{2'd1,1,0,0,0,0,1,0,0, 24'd3, 24'd6,      8'd4,  24'd4, 1,0, 8'd7},  // R7 A only
    '{2'd2,0,0,0,0,0,0,1,0, 24'd4, 24'hFFFFFF, 8'd6,  24'd2, 0,1, 8'd9},  // R9 runs, clears
    '{2'd2,0,1,0,0,0,0,1,0, 24'd4, 24'hFFFFFF, 8'd6,  24'd0, 0,0, 8'd9},  // R9 stopped
    '{2'd3,1,0,1,1,1,1,1,0, 24'd2, 24'd3,      8'd6,  24'd0, 0,0, 8'd2},  // R2 frozen
    '{2'd1,1,0,0,0,0,0,0,1, 24'd2, 24'd100,    8'd2,  24'd2, 0,0, 8'd7},  // R7 preset 1
    '{2'd0,1,0,1,0,0,0,0,0, 24'd2, 24'hFFFFFF, 8'd3,  24'd1, 0,0, 8'd6}   // R6 no irq
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic srst();
    sync_rst_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    sync_rst_i = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cfg(logic [1:0] m, logic en, logic zc, logic [23:0] ca, logic [23:0] cb);
    mode_i = m; tmr_en_i = en; zero_clr_en_i = zc; cmp_a_i = ca; cmp_b_i = cb;
    wd_dis_i = 1'b0; clk_src_i = 1'b0; div_en_i = 1'b0; div_sel_i = 3'd0;
    int_ival_en_i = 1'b1; int_a_en_i = 1'b1; int_b_en_i = 1'b1; int_wd_en_i = 1'b1;
    ffi_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL timeout: run did not complete");
      finish_run();
    end
  end

  initial begin
    // R1 asynchronous reset state
    run(3);
    chk("R1", "count", count_o, 0);
    chk("R1", "set", set_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "ff", ff_o, 0);
    rst_ni = 1'b1;
    run(2);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      mode_i = VECS[i].mode; tmr_en_i = VECS[i].en; wd_dis_i = VECS[i].wd_dis;
      zero_clr_en_i = VECS[i].zc; int_ival_en_i = VECS[i].ie_iv;
      int_a_en_i = VECS[i].ie_a; int_b_en_i = VECS[i].ie_b; int_wd_en_i = VECS[i].ie_wd;
      ffi_i = VECS[i].ffi; cmp_a_i = VECS[i].ca; cmp_b_i = VECS[i].cb;
      clk_src_i = 1'b0; div_en_i = 1'b0; div_sel_i = 3'd0;
      srst();
      run(int'(VECS[i].n));
      chk(tag, $sformatf("vec%0d count", i), count_o, VECS[i].exp_cnt);
      chk(tag, $sformatf("vec%0d ff", i), ff_o, VECS[i].exp_ff);
      chk(tag, $sformatf("vec%0d irq", i), irq_o, VECS[i].exp_irq);
    end

    // R1 sync reset presets ff from ffi
    cfg(2'd3, 1'b0, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
    ffi_i = 1'b1;
    srst();
    chk("R1", "ff preset", ff_o, 1);

    // R3 prescaler divide by 4, 2 and 256
    cfg(2'd1, 1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
    div_en_i = 1'b1; div_sel_i = 3'd1;
    srst();
    run(15);
    chk("R3", "div4 at 15", count_o, 3);
    run(1);
    chk("R3", "div4 at 16", count_o, 4);
    div_sel_i = 3'd0;
    srst();
    run(10);
    chk("R3", "div2 at 10", count_o, 5);
    div_sel_i = 3'd7;
    srst();
    run(300);
    chk("R3", "div256 at 300", count_o, 1);

    // R4 external tick, R3 internal clock ignored
    cfg(2'd1, 1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFFF);
    clk_src_i = 1'b1;
    srst();
    run(20);
    chk("R3", "ext select idle", count_o, 0);
    for (int p = 0; p < 4; p++) begin
      ext_tick_i = 1'b1; run(3);
      ext_tick_i = 1'b0; run(3);
    end
    chk("R4", "four ext pulses", count_o, 4);
    ext_tick_i = 1'b1; run(10);
    ext_tick_i = 1'b0; run(4);
    chk("R4", "long ext level", count_o, 5);

    // R11 / R6 interval strobe timing
    cfg(2'd0, 1'b1, 1'b1, 24'd3, 24'hFFFFFF);
    srst();
    run(3);
    chk("R11", "interval strobe", set_o, 4'b0001);
    chk("R6", "reloaded", count_o, 0);
    run(1);
    chk("R11", "strobe dropped", set_o, 4'b0000);

    // R7 / R8 pulse strobes
    cfg(2'd1, 1'b1, 1'b0, 24'd2, 24'd4);
    srst();
    run(2);
    chk("R7", "pulse A strobe", set_o, 4'b0010);
    chk("R7", "ff after A", ff_o, 1);
    run(2);
    chk("R8", "pulse B strobe", set_o, 4'b0100);
    chk("R8", "ff after B", ff_o, 0);
    chk("R8", "count cleared", count_o, 0);

    // R9 watchdog strobe
    cfg(2'd2, 1'b1, 1'b0, 24'd2, 24'hFFFFFF);
    srst();
    run(2);
    chk("R9", "watchdog strobe", set_o, 4'b1000);
    chk("R9", "watchdog cleared", count_o, 0);

    // R10 sticky irq and clear; R5 no repeat while holding
    cfg(2'd0, 1'b1, 1'b0, 24'd2, 24'hFFFFFF);
    srst();
    run(10);
    chk("R10", "irq held", irq_o, 1);
    status_clr_i = 1'b1; run(1);
    status_clr_i = 1'b0;
    chk("R10", "irq cleared", irq_o, 0);
    run(5);
    chk("R5", "no repeat irq on hold", irq_o, 0);
    chk("R5", "still holding", count_o, 2);

    done = 1'b1;
    finish_run();
  end
endmodule